// File: doc/BRIEF.md
# Realigning Sixteen-Lane SAD Accumulator

This block finds the matching error between one row of a luminance macroblock and one row of a motion-search candidate. The candidate row may begin at any byte address. The memory returns only aligned 128-bit words, so the caller supplies the two aligned words that cover the row, plus the low four address bits. The block cuts the sixteen wanted bytes out of that 256-bit pair. In the same cycle it forms all sixteen absolute pixel differences against the reference row, reduces them to one row total and adds that total into a running sum.

A search controller drives the block. It pulses a start input at the first row of each candidate block and then streams one row per cycle, qualified by a valid input. One cycle after the sixteenth row is accepted, a done pulse marks that the output holds the finished block total. The controller compares that total against the other candidates and keeps the smallest.

Top module: `sad_row_accum`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `sad_out` reads 0 and `done` reads 0.
- R2: The aligned row's lane i is byte (off+i) of the 32-byte pair. Bytes 0..15 are `lo_word` and bytes 16..31 are `hi_word`, and byte k of a word occupies bits [8k+7:8k]. An offset of 0 yields `lo_word` unchanged.
- R3: A row's contribution is the sum over 16 lanes of |cur−ref| on unsigned 8-bit pixels. It is the same whichever operand is larger, and it reaches 4080 for 255 against 0.
- R4: Each accepted row, with `row_valid` high, no `start`, and fewer than 16 rows taken, adds its contribution to `sad_out`. The new total is visible after the clock edge that accepts it.
- R5: `start` with `row_valid` low makes `sad_out` 0 and the row count 0 after the edge.
- R6: `start` with `row_valid` high discards the old total, so `sad_out` becomes that row's contribution and the row counts as the first of a new block.
- R7: `done` is high for exactly one cycle: the cycle after the 16th row of a block is accepted. In that cycle `sad_out` holds the block total.
- R8: After 16 rows, further valid rows are ignored and `sad_out` holds until the next `start`.
- R9: Cycles with both `start` and `row_valid` low leave `sad_out` unchanged, whatever the data inputs carry.
- R10: The 16-bit total never wraps. A block of 16 rows of 255 against 0 gives exactly 65280.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a new block and clears the running sum |
| row_valid | input | 1 | A row is present on the data inputs this cycle |
| lo_word | input | 128 | Aligned word holding the row's first byte |
| hi_word | input | 128 | Next aligned word |
| byte_off | input | 4 | Low address bits of the row's first byte |
| ref_row | input | 128 | Current-macroblock row, lane i in bits [8i+7:8i] |
| sad_out | output | 16 | Running and final block SAD |
| done | output | 1 | One-cycle pulse: block total is ready |

## Verification
The bench builds the block with its default values: sixteen 8-bit lanes and sixteen rows per block. Those values bring every byte offset from 0 to 15 within reach, as well as the exact 65280 ceiling of the 16-bit total. Directed rows of ascending byte values make each offset give a distinct row total, so a wrong shift is visible at the output. Random blocks mix idle gaps, mid-block restarts and rows past the sixteenth, and each one is scored against a per-cycle reference model.

// File: rtl/sad_pkg.sv
package sad_pkg;

    localparam int unsigned DEF_LANES = 16;
    localparam int unsigned DEF_PIX_W = 8;
    localparam int unsigned DEF_ROWS  = 16;

    typedef enum logic [1:0] {
        ACC_HOLD  = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_ADD   = 2'd2,
        ACC_CLEAR = 2'd3
    } acc_op_e;

    // width that holds one row total: lanes * (2^pix_w - 1)
    function automatic int unsigned row_sad_width(int unsigned pix_w, int unsigned lanes);
        return pix_w + $clog2(lanes);
    endfunction

    // width that holds a full block total
    function automatic int unsigned block_sad_width(int unsigned pix_w, int unsigned lanes,
                                                    int unsigned rows);
        return pix_w + $clog2(lanes) + $clog2(rows);
    endfunction

endpackage

// File: rtl/sad_row_aligner.sv
module sad_row_aligner #(
    parameter int unsigned LANES = 16,
    parameter int unsigned PIX_W = 8,
    localparam int unsigned WORD_W = LANES * PIX_W,
    localparam int unsigned OFF_W  = $clog2(LANES)
) (
    input  logic [WORD_W-1:0] lo_word,
    input  logic [WORD_W-1:0] hi_word,
    input  logic [OFF_W-1:0]  byte_off,
    output logic [WORD_W-1:0] win
);
    localparam int unsigned PAIR_W = 2 * WORD_W;
    localparam int unsigned IDX_W  = $clog2(PAIR_W);

    logic [PAIR_W-1:0] pair;
    assign pair = {hi_word, lo_word};

    for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
        logic [IDX_W-1:0] base;
        assign base = IDX_W'((int'(byte_off) + lane) * PIX_W);
        assign win[lane*PIX_W +: PIX_W] = pair[base +: PIX_W];
    end

endmodule

// File: rtl/sad_lane_absdiff.sv
module sad_lane_absdiff #(
    parameter int unsigned LANES = 16,
    parameter int unsigned PIX_W = 8,
    localparam int unsigned WORD_W = LANES * PIX_W,
    localparam int unsigned ABS_W  = PIX_W + 1
) (
    input  logic [WORD_W-1:0]      cur_row,
    input  logic [WORD_W-1:0]      ref_row,
    output logic [LANES*ABS_W-1:0] abs_row
);
    for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
        logic signed [ABS_W-1:0] diff;
        assign diff = $signed({1'b0, cur_row[lane*PIX_W +: PIX_W]})
                    - $signed({1'b0, ref_row[lane*PIX_W +: PIX_W]});
        assign abs_row[lane*ABS_W +: ABS_W] = diff[ABS_W-1] ? $unsigned(-diff) : $unsigned(diff);
    end

endmodule

// File: rtl/sad_reduce_tree.sv
module sad_reduce_tree #(
    parameter int unsigned LANES = 16,
    parameter int unsigned IN_W  = 9,
    parameter int unsigned OUT_W = 12
) (
    input  logic [LANES*IN_W-1:0] terms,
    output logic [OUT_W-1:0]      total
);
    logic [OUT_W-1:0] node [LANES];

    // pairwise halving: level width w folds into the lower w entries
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            node[i] = OUT_W'(terms[i*IN_W +: IN_W]);
        end
        for (int w = LANES / 2; w >= 1; w = w / 2) begin
            for (int i = 0; i < w; i++) begin
                node[i] = node[2*i] + node[2*i+1];
            end
        end
        total = node[0];
    end

endmodule

// File: rtl/sad_row_ctrl.sv
module sad_row_ctrl
    import sad_pkg::*;
#(
    parameter int unsigned ROWS = 16,
    localparam int unsigned CNT_W = $clog2(ROWS + 1)
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    row_valid,
    output acc_op_e op,
    output logic    done
);
    logic [CNT_W-1:0] rows_q;
    logic [CNT_W-1:0] rows_d;
    logic             full;
    logic             done_d;

    assign full = (rows_q == CNT_W'(ROWS));

    always_comb begin
        op     = ACC_HOLD;
        rows_d = rows_q;
        done_d = 1'b0;
        if (start && row_valid) begin
            op     = ACC_LOAD;
            rows_d = CNT_W'(1);
            done_d = (ROWS == 1);
        end else if (start) begin
            op     = ACC_CLEAR;
            rows_d = '0;
        end else if (row_valid && !full) begin
            op     = ACC_ADD;
            rows_d = rows_q + CNT_W'(1);
            done_d = (rows_q == CNT_W'(ROWS - 1));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rows_q <= '0;
            done   <= 1'b0;
        end else begin
            rows_q <= rows_d;
            done   <= done_d;
        end
    end

    AST_FULL_IGNORES: assert property (@(posedge clk) disable iff (rst)
        (full && !start) |=> (rows_q == CNT_W'(ROWS))) else $error("full block took a row"); // R8

endmodule

// File: rtl/sad_acc_reg.sv
module sad_acc_reg
    import sad_pkg::*;
#(
    parameter int unsigned ROW_W = 12,
    parameter int unsigned ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  acc_op_e          op,
    input  logic [ROW_W-1:0] row_sad,
    output logic [ACC_W-1:0] sum
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sum <= '0;
        end else begin
            unique case (op)
                ACC_LOAD:  sum <= ACC_W'(row_sad);
                ACC_ADD:   sum <= sum + ACC_W'(row_sad);
                ACC_CLEAR: sum <= '0;
                default:   sum <= sum;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (op == ACC_ADD) |=> (sum >= $past(sum))) else $error("accumulator wrapped"); // R10

endmodule

// File: rtl/sad_row_accum.sv
module sad_row_accum
    import sad_pkg::*;
#(
    parameter int unsigned LANES = DEF_LANES,
    parameter int unsigned PIX_W = DEF_PIX_W,
    parameter int unsigned ROWS  = DEF_ROWS,
    localparam int unsigned WORD_W = LANES * PIX_W,
    localparam int unsigned OFF_W  = $clog2(LANES),
    localparam int unsigned ACC_W  = block_sad_width(PIX_W, LANES, ROWS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              row_valid,
    input  logic [WORD_W-1:0] lo_word,
    input  logic [WORD_W-1:0] hi_word,
    input  logic [OFF_W-1:0]  byte_off,
    input  logic [WORD_W-1:0] ref_row,
    output logic [ACC_W-1:0]  sad_out,
    output logic              done
);
    localparam int unsigned ABS_W = PIX_W + 1;
    localparam int unsigned ROW_W = row_sad_width(PIX_W, LANES);

    logic [WORD_W-1:0]      win;
    logic [LANES*ABS_W-1:0] abs_row;
    logic [ROW_W-1:0]       row_sad;
    acc_op_e                op;

    sad_row_aligner #(.LANES(LANES), .PIX_W(PIX_W)) u_align (
        .lo_word (lo_word),
        .hi_word (hi_word),
        .byte_off(byte_off),
        .win     (win)
    );

    sad_lane_absdiff #(.LANES(LANES), .PIX_W(PIX_W)) u_absdiff (
        .cur_row(win),
        .ref_row(ref_row),
        .abs_row(abs_row)
    );

    sad_reduce_tree #(.LANES(LANES), .IN_W(ABS_W), .OUT_W(ROW_W)) u_tree (
        .terms(abs_row),
        .total(row_sad)
    );

    sad_row_ctrl #(.ROWS(ROWS)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .row_valid(row_valid),
        .op       (op),
        .done     (done)
    );

    sad_acc_reg #(.ROW_W(ROW_W), .ACC_W(ACC_W)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .row_sad(row_sad),
        .sum    (sad_out)
    );

    AST_ZERO_OFFSET: assert property (@(posedge clk) disable iff (rst)
        (byte_off == '0) |-> (win == lo_word)) else $error("offset 0 not pass-through"); // R2

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done longer than one cycle"); // R7

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (start && !row_valid) |=> (sad_out == '0 && !done)) else $error("start did not clear"); // R5

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!start && !row_valid) |=> $stable(sad_out)) else $error("idle cycle moved sum"); // R9

endmodule

// File: tb/sad_row_accum_bench.sv
`timescale 1ns/1ps
module sad_row_accum_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         row_valid = 1'b0;
    logic [127:0] lo_word = '0;
    logic [127:0] hi_word = '0;
    logic [3:0]   byte_off = '0;
    logic [127:0] ref_row = '0;
    logic [15:0]  sad_out;
    logic         done;

    int n_checks = 0;
    int n_fail   = 0;
    int m_sum    = 0;
    int m_rows   = 0;
    bit m_done   = 1'b0;

    always #2 clk = ~clk;

    sad_row_accum u_sad_row_accum (
        .clk(clk), .rst(rst), .start(start), .row_valid(row_valid),
        .lo_word(lo_word), .hi_word(hi_word), .byte_off(byte_off),
        .ref_row(ref_row), .sad_out(sad_out), .done(done)
    );

    function automatic logic [127:0] f_window(logic [127:0] lo, logic [127:0] hi, int off);
        logic [7:0]   bytes [32];
        logic [127:0] r;
        for (int k = 0; k < 16; k++) begin
            bytes[k]    = lo[8*k +: 8];
            bytes[k+16] = hi[8*k +: 8];
        end
        for (int i = 0; i < 16; i++) r[8*i +: 8] = bytes[off + i];
        return r;
    endfunction

    function automatic int f_row_sad(logic [127:0] a, logic [127:0] b);
        int s = 0;
        for (int i = 0; i < 16; i++) begin
            int x = int'(a[8*i +: 8]);
            int y = int'(b[8*i +: 8]);
            s += (x > y) ? x - y : y - x;
        end
        return s;
    endfunction

    function automatic logic [127:0] f_rand128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input bit s, input bit v, input logic [127:0] lo, input logic [127:0] hi,
                       input logic [3:0] off, input logic [127:0] rf);
        int rs;
        @(negedge clk);
        start = s; row_valid = v; lo_word = lo; hi_word = hi; byte_off = off; ref_row = rf;
        @(posedge clk);
        rs = f_row_sad(f_window(lo, hi, int'(off)), rf);
        if (s && v) begin
            m_sum = rs; m_rows = 1; m_done = 1'b0;
        end else if (s) begin
            m_sum = 0; m_rows = 0; m_done = 1'b0;
        end else if (v && m_rows < 16) begin
            m_sum += rs; m_rows++; m_done = (m_rows == 16);
        end else begin
            m_done = 1'b0;
        end
        #1;
        check(int'(sad_out) == m_sum, "R4 running total", int'(sad_out), m_sum);
        check(done == m_done, "R7 done timing", int'(done), int'(m_done));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        logic [127:0] ones;
        logic [127:0] ramp_lo;
        logic [127:0] ramp_hi;
        ones = '1;
        for (int k = 0; k < 16; k++) begin
            ramp_lo[8*k +: 8] = 8'(k + 1);
            ramp_hi[8*k +: 8] = 8'(k + 17);
        end
        void'($urandom(32'd20240611));

        repeat (3) @(posedge clk);
        #1;
        check(sad_out == 16'd0, "R1 sad in reset", int'(sad_out), 0);
        check(done == 1'b0, "R1 done in reset", int'(done), 0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check(sad_out == 16'd0, "R1 sad after reset", int'(sad_out), 0);
        check(done == 1'b0, "R1 done after reset", int'(done), 0);

        // R2: ascending bytes, zero reference: each offset gives 16*off+136
        for (int o = 0; o < 16; o++) begin
            cyc(1'b1, 1'b1, ramp_lo, ramp_hi, 4'(o), '0);
            check(int'(sad_out) == 16 * o + 136, "R2 offset extraction", int'(sad_out), 16 * o + 136);
        end

        // R3 and R6: restart with a row, both difference directions
        cyc(1'b1, 1'b1, ones, ones, 4'd7, '0);
        check(int'(sad_out) == 4080, "R3 cur above ref / R6 load", int'(sad_out), 4080);
        cyc(1'b1, 1'b1, '0, '0, 4'd3, ones);
        check(int'(sad_out) == 4080, "R3 ref above cur / R6 load", int'(sad_out), 4080);

        // R9: idle cycle with busy data
        cyc(1'b0, 1'b0, f_rand128(), f_rand128(), 4'd9, f_rand128());
        check(int'(sad_out) == 4080, "R9 idle holds", int'(sad_out), 4080);

        // R5: start alone clears
        cyc(1'b1, 1'b0, ones, ones, 4'd0, '0);
        check(int'(sad_out) == 0, "R5 clear", int'(sad_out), 0);

        // R10 and R7: worst-case block
        for (int r = 0; r < 16; r++) cyc(r == 0, 1'b1, ones, ones, 4'(r), '0);
        check(int'(sad_out) == 65280, "R10 max block", int'(sad_out), 65280);
        check(done == 1'b1, "R7 done after 16th row", int'(done), 1);
        cyc(1'b0, 1'b0, '0, '0, 4'd0, '0);
        check(done == 1'b0, "R7 done drops", int'(done), 0);

        // R8: rows after the block are ignored
        cyc(1'b0, 1'b1, '0, '0, 4'd0, ones);
        cyc(1'b0, 1'b1, ramp_lo, ramp_hi, 4'd5, '0);
        check(int'(sad_out) == 65280, "R8 extra rows ignored", int'(sad_out), 65280);
        check(done == 1'b0, "R8 no second done", int'(done), 0);

        // random blocks with gaps, restarts and overruns
        for (int b = 0; b < 40; b++) begin
            cyc(1'b1, 1'($urandom % 2), f_rand128(), f_rand128(), 4'($urandom), f_rand128());
            for (int j = 0; j < 30; j++) begin
                bit rs_start = (($urandom % 25) == 0);
                bit rs_valid = (($urandom % 4) != 0);
                cyc(rs_start, rs_valid, f_rand128(), f_rand128(), 4'($urandom), f_rand128());
            end
        end

        @(negedge clk);
        start = 1'b0; row_valid = 1'b0;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule